// File: doc/BRIEF.md
# Compare-and-flag status unit

This block runs flag-only comparisons on two operands and keeps a persistent four-bit status register of negative, zero, carry and overflow flags. It never produces a result word. A subtracting compare refreshes all four flags. Two logical tests, a bitwise AND and a bitwise XOR, refresh only negative and zero. Each logical test keeps the carry flag unless a shifted second operand supplies a new carry, and it always keeps the overflow flag. Because the logical tests leave carry and overflow alone, an equality check can sit between the steps of a multi-word arithmetic chain without breaking it.

Next to the register is a condition evaluator. It compares a 4-bit condition selector with the current flags and drives a single take/skip bit, which a branch unit uses to decide a conditional jump. The selector covers equality, sign, carry, overflow, and the unsigned and signed orderings. It also has an always-true code and a never-true code. The flags change only on a clock edge that sees the valid strobe high. The condition output is combinational from the registered flags.

Top module: `cmp_flag_unit`

## Requirements
- R1: An active-low asynchronous reset clears all four flags to 0. The flag output flagsOut packs the flags as bit 3 = N, bit 2 = Z, bit 1 = C and bit 0 = V.
- R2: On a clock edge where opValid is low, flagsOut keeps its value whatever the other inputs are.
- R3: The compare operation (opSel = 00) computes opA minus opB. It sets N to the top bit of the difference and Z when the difference is zero. It sets C when opA is unsigned greater than or equal to opB (no borrow) and V on signed overflow of the difference. shiftApplied and shiftCarry have no effect on a compare.
- R4: The bit-test operation (opSel = 01) sets N and Z from opA AND opB. V keeps its value. C keeps its value when shiftApplied is low.
- R5: The equality-test operation (opSel = 10) sets N and Z from opA XOR opB. V keeps its value. C keeps its value when shiftApplied is low.
- R6: During a bit-test or equality-test with shiftApplied high, C takes the value of shiftCarry.
- R7: opSel = 11 is a no-operation: flagsOut does not change even with opValid high.
- R8: Condition codes 0 to 7 are EQ (Z), NE (!Z), CS (C), CC (!C), MI (N), PL (!N), VS (V) and VC (!V), evaluated on the current flags.
- R9: Codes 8 and 9 are HI (C and !Z) and LS (!C or Z). After a compare, CS, CC, HI and LS match opA >= opB, opA < opB, opA > opB and opA <= opB as unsigned numbers.
- R10: Codes 10 to 13 are GE (N == V), LT (N != V), GT (!Z and N == V) and LE (Z or N != V). After a compare they match the signed relations >=, <, > and <= between opA and opB.
- R11: Code 14 always gives condTake = 1. Code 15 always gives condTake = 0.
- R12: condTake is combinational from the registered flags and condSel. It follows a change of condSel without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation strobe; flags update on an edge where it is high |
| opSel | input | 2 | 00 compare, 01 bit-test, 10 equality-test, 11 no-op |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand, already shifted if a shift was applied |
| shiftApplied | input | 1 | The second operand went through the shifter |
| shiftCarry | input | 1 | Carry-out of the shifter |
| condSel | input | 4 | Condition selector |
| flagsOut | output | 4 | Status register {N, Z, C, V} |
| condTake | output | 1 | Selected condition holds on the current flags |

## Verification
The bench compares every pair from a set of boundary operands, including 0, 1, the largest positive value, the most negative value and all ones. After each compare it checks all sixteen condition codes against the unsigned and signed relations, which it computes directly.

Several design errors show up this way:
- Inverting the borrow sense flips CS, CC, HI and LS on every unequal pair.
- A wrong overflow term breaks GE, LT, GT and LE only across the sign boundary, for example the most negative value minus one.

The logical tests run on top of known carry and overflow values, with and without a shift. A design that clears C or V here, or that ignores the shifter carry, would break a multi-word chain. The no-op code and a held-low valid strobe carry operands that would change every flag, so any leak into the register shows at the output.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

  typedef enum logic [1:0] {
    OP_CMP = 2'b00,
    OP_AND = 2'b01,
    OP_XOR = 2'b10,
    OP_NOP = 2'b11
  } opKind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic ldNz;
    logic ldCarryArith;
    logic ldCarryShift;
    logic ldOvf;
    logic useDiff;
    logic useXor;
  } flagStrobe_t;

  localparam logic [3:0] CC_EQ = 4'd0;
  localparam logic [3:0] CC_NE = 4'd1;
  localparam logic [3:0] CC_CS = 4'd2;
  localparam logic [3:0] CC_CC = 4'd3;
  localparam logic [3:0] CC_MI = 4'd4;
  localparam logic [3:0] CC_PL = 4'd5;
  localparam logic [3:0] CC_VS = 4'd6;
  localparam logic [3:0] CC_VC = 4'd7;
  localparam logic [3:0] CC_HI = 4'd8;
  localparam logic [3:0] CC_LS = 4'd9;
  localparam logic [3:0] CC_GE = 4'd10;
  localparam logic [3:0] CC_LT = 4'd11;
  localparam logic [3:0] CC_GT = 4'd12;
  localparam logic [3:0] CC_LE = 4'd13;
  localparam logic [3:0] CC_AL = 4'd14;

endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import cfu_pkg::*;
(
  input  logic        opValid,
  input  logic [1:0]  opSel,
  input  logic        shiftApplied,
  output flagStrobe_t strb
);
  opKind_e kind;

  always_comb begin
    kind = opKind_e'(opSel);
    strb = '0;
    if (opValid) begin
      unique case (kind)
        OP_CMP: begin
          strb.ldNz         = 1'b1;
          strb.ldCarryArith = 1'b1;
          strb.ldOvf        = 1'b1;
          strb.useDiff      = 1'b1;
        end
        OP_AND: begin
          strb.ldNz         = 1'b1;
          strb.ldCarryShift = shiftApplied;
        end
        OP_XOR: begin
          strb.ldNz         = 1'b1;
          strb.ldCarryShift = shiftApplied;
          strb.useXor       = 1'b1;
        end
        default: strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/flag_datapath.sv
module flag_datapath
  import cfu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              shiftCarry,
  input  flagStrobe_t       strb,
  output flags_t            flagsQ
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   diffExt;
  logic [DATA_W-1:0] diff;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] selRes;
  logic              noBorrow;
  logic              sgnOvf;
  flags_t            flagsD;

  always_comb begin
    diffExt  = {1'b0, opA} - {1'b0, opB};
    diff     = diffExt[DATA_W-1:0];
    noBorrow = ~diffExt[DATA_W];
    sgnOvf   = (opA[MSB] ^ opB[MSB]) & (opA[MSB] ^ diff[MSB]);
    logicRes = strb.useXor ? (opA ^ opB) : (opA & opB);
    selRes   = strb.useDiff ? diff : logicRes;
  end

  always_comb begin
    flagsD = flagsQ;
    if (strb.ldNz) begin
      flagsD.n = selRes[MSB];
      flagsD.z = (selRes == '0);
    end
    if (strb.ldCarryArith)      flagsD.c = noBorrow;
    else if (strb.ldCarryShift) flagsD.c = shiftCarry;
    if (strb.ldOvf)             flagsD.v = sgnOvf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= flagsD;
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cfu_pkg::*;
(
  input  flags_t     flags,
  input  logic [3:0] condSel,
  output logic       take
);
  logic sgnLess;

  always_comb begin
    sgnLess = flags.n ^ flags.v;
    unique case (condSel)
      CC_EQ:   take = flags.z;
      CC_NE:   take = ~flags.z;
      CC_CS:   take = flags.c;
      CC_CC:   take = ~flags.c;
      CC_MI:   take = flags.n;
      CC_PL:   take = ~flags.n;
      CC_VS:   take = flags.v;
      CC_VC:   take = ~flags.v;
      CC_HI:   take = flags.c & ~flags.z;
      CC_LS:   take = ~flags.c | flags.z;
      CC_GE:   take = ~sgnLess;
      CC_LT:   take = sgnLess;
      CC_GT:   take = ~flags.z & ~sgnLess;
      CC_LE:   take = flags.z | sgnLess;
      CC_AL:   take = 1'b1;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
  import cfu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              shiftApplied,
  input  logic              shiftCarry,
  input  logic [3:0]        condSel,
  output logic [3:0]        flagsOut,
  output logic              condTake
);
  flagStrobe_t strb;
  flags_t      flagsQ;

  flag_ctrl u_ctrl (
    .opValid      (opValid),
    .opSel        (opSel),
    .shiftApplied (shiftApplied),
    .strb         (strb)
  );

  flag_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .opA        (opA),
    .opB        (opB),
    .shiftCarry (shiftCarry),
    .strb       (strb),
    .flagsQ     (flagsQ)
  );

  cond_eval u_cond (
    .flags   (flagsQ),
    .condSel (condSel),
    .take    (condTake)
  );

  assign flagsOut = flagsQ;
endmodule

// File: rtl/cfu_checker.sv
module cfu_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [1:0]        opSel,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              shiftApplied,
  input logic              shiftCarry,
  input logic [3:0]        condSel,
  input logic [3:0]        flagsOut,
  input logic              condTake
);
  // R1
  always @(posedge clk)
    if (!rstN) reset_clear_chk: assert (flagsOut == 4'b0000);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(flagsOut));

  // R7
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 2'b11) |=> $stable(flagsOut));

  // R3
  cmp_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 2'b00) |=> (flagsOut[1] == ($past(opA) >= $past(opB))));

  // R3
  cmp_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 2'b00) |=> (flagsOut[2] == ($past(opA) == $past(opB))));

  // R4
  test_ovf_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opSel == 2'b01 || opSel == 2'b10)) |=> $stable(flagsOut[0]));

  // R5
  test_carry_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opSel == 2'b01 || opSel == 2'b10) && !shiftApplied) |=> $stable(flagsOut[1]));

  // R6
  shift_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opSel == 2'b01 || opSel == 2'b10) && shiftApplied)
      |=> (flagsOut[1] == $past(shiftCarry)));

  // R11
  cond_always_chk: assert property (@(posedge clk) disable iff (!rstN)
    (condSel == 4'd14) |-> condTake);

  // R11
  cond_never_chk: assert property (@(posedge clk) disable iff (!rstN)
    (condSel == 4'd15) |-> !condTake);
endmodule

bind cmp_flag_unit cfu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .opValid      (opValid),
  .opSel        (opSel),
  .opA          (opA),
  .opB          (opB),
  .shiftApplied (shiftApplied),
  .shiftCarry   (shiftCarry),
  .condSel      (condSel),
  .flagsOut     (flagsOut),
  .condTake     (condTake)
);

// File: tb/cmp_flag_unit_bench.sv
`timescale 1ns/1ps
module cmp_flag_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        shiftApplied = 1'b0;
  logic        shiftCarry = 1'b0;
  logic [3:0]  condSel = 4'd0;
  logic [3:0]  flagsOut;
  logic        condTake;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmp_flag_unit u_cmp_flag_unit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel), .opA(opA), .opB(opB),
    .shiftApplied(shiftApplied), .shiftCarry(shiftCarry), .condSel(condSel),
    .flagsOut(flagsOut), .condTake(condTake)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic vld, input logic [1:0] op, input logic [31:0] a,
                      input logic [31:0] b, input logic sh, input logic shc);
    @(negedge clk);
    opValid = vld; opSel = op; opA = a; opB = b; shiftApplied = sh; shiftCarry = shc;
    @(negedge clk);
    opValid = 1'b0;
    #0.5;
  endtask

  function automatic logic [3:0] cmpFlags(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] d;
    longint sd;
    logic vv;
    d  = a - b;
    sd = longint'($signed(a)) - longint'($signed(b));
    vv = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
    return {d[31], d == 0, a >= b, vv};
  endfunction

  logic [31:0] vals [7] = '{32'h0, 32'h1, 32'h7, 32'h7fffffff, 32'h80000000,
                           32'h80000001, 32'hffffffff};

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] expF;
    #12;
    check("R1 reset flags", {28'b0, flagsOut}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    // Sweep compare over boundary pairs, then every condition code
    for (int i = 0; i < 7; i++) begin
      for (int j = 0; j < 7; j++) begin
        logic [31:0] a, b, d;
        logic sa;
        a = vals[i]; b = vals[j]; d = a - b;
        // R3: shift inputs must not matter for compare
        doOp(1'b1, 2'b00, a, b, (i % 2 == 0), (j % 2 == 0));
        check("R3 compare flags", {28'b0, flagsOut}, {28'b0, cmpFlags(a, b)});
        for (int k = 0; k < 16; k++) begin
          logic e;
          string tag;
          sa = $signed(a) < $signed(b);
          case (k)
            0:  begin e = (a == b);  tag = "R8 EQ"; end
            1:  begin e = (a != b);  tag = "R8 NE"; end
            2:  begin e = (a >= b);  tag = "R9 CS"; end
            3:  begin e = (a <  b);  tag = "R9 CC"; end
            4:  begin e = d[31];     tag = "R8 MI"; end
            5:  begin e = !d[31];    tag = "R8 PL"; end
            6:  begin e = cmpFlags(a, b)[0];  tag = "R8 VS"; end
            7:  begin e = !cmpFlags(a, b)[0]; tag = "R8 VC"; end
            8:  begin e = (a >  b);  tag = "R9 HI"; end
            9:  begin e = (a <= b);  tag = "R9 LS"; end
            10: begin e = !sa;       tag = "R10 GE"; end
            11: begin e = sa;        tag = "R10 LT"; end
            12: begin e = !sa && (a != b); tag = "R10 GT"; end
            13: begin e = sa || (a == b);  tag = "R10 LE"; end
            14: begin e = 1'b1;      tag = "R11 AL"; end
            default: begin e = 1'b0; tag = "R11 never"; end
          endcase
          condSel = 4'(k);
          #0.2;
          // R12: sampled with no clock edge since condSel changed
          check(tag, {31'b0, condTake}, {31'b0, e});
        end
      end
    end

    // Logical tests on top of known C=1,V=1 (0x80000000 - 1)
    doOp(1'b1, 2'b00, 32'h80000000, 32'h1, 1'b0, 1'b0);
    check("R3 setup C,V", {28'b0, flagsOut}, 32'h3);
    doOp(1'b1, 2'b01, 32'hf0000000, 32'h80000000, 1'b0, 1'b0);
    check("R4 and keeps C,V", {28'b0, flagsOut}, 32'hb);
    doOp(1'b1, 2'b01, 32'h0000ff00, 32'h000000ff, 1'b0, 1'b0);
    check("R4 and zero", {28'b0, flagsOut}, 32'h7);
    doOp(1'b1, 2'b10, 32'h12345678, 32'h12345678, 1'b0, 1'b1);
    check("R5 xor equal keeps C,V", {28'b0, flagsOut}, 32'h7);
    doOp(1'b1, 2'b10, 32'h00000000, 32'h80000000, 1'b0, 1'b0);
    check("R5 xor negative", {28'b0, flagsOut}, 32'hb);
    doOp(1'b1, 2'b10, 32'h1, 32'h2, 1'b1, 1'b0);
    check("R6 xor shift carry 0", {28'b0, flagsOut}, 32'h1);
    doOp(1'b1, 2'b01, 32'h3, 32'h1, 1'b1, 1'b1);
    check("R6 and shift carry 1", {28'b0, flagsOut}, 32'h3);

    // No-op and idle must leave flags alone
    expF = flagsOut;
    doOp(1'b1, 2'b11, 32'h0, 32'h0, 1'b1, 1'b0);
    check("R7 nop hold", {28'b0, flagsOut}, {28'b0, expF});
    doOp(1'b0, 2'b00, 32'h0, 32'h0, 1'b0, 1'b0);
    check("R2 idle hold", {28'b0, flagsOut}, {28'b0, expF});
    doOp(1'b0, 2'b10, 32'h80000000, 32'h0, 1'b1, 1'b0);
    check("R2 idle hold test", {28'b0, flagsOut}, {28'b0, expF});

    // R12: condTake follows condSel between edges
    condSel = 4'd2; #0.2;
    check("R12 CS now", {31'b0, condTake}, 32'h1);
    condSel = 4'd7; #0.2;
    check("R12 VC now", {31'b0, condTake}, 32'h0);

    // R1: reset mid-run clears nonzero flags
    @(negedge clk); rstN = 1'b0; #0.5;
    check("R1 reset mid-run", {28'b0, flagsOut}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule